// File: doc/BRIEF.md
# Scrambling NRZI Video Serializer

This block turns a stream of 10-bit parallel video words into a single serial bitstream for a serial digital video link. It runs entirely on the serial bit clock. A one-cycle word strobe, pulsed once every ten bit clocks, loads a word into a shift register. The word then leaves least significant bit first, one bit per clock. Each bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1 and then through an NRZ-to-NRZI stage before it reaches a registered serial output. A bypass control routes the raw shifted bits straight to the output instead. The scrambler and level state keep running underneath the bypass.

A narrow mode accepts 8-bit sources by left-aligning the byte in the 10-bit word. An in-line detector watches the loaded words for the timing reference preamble (all ones, all zeros, all zeros) and raises a flag. A disable input forces that flag low. Clock multiplication, rate selection and line drivers are outside this block.

Top module: `vid_serializer`

## Requirements
- R1: A synchronous active-high reset clears the shift register, bit counter, scrambler state, NRZI level, sync history and both outputs. While all-zero words are then sent, `ser_out` stays 0.
- R2: A word strobe sampled at clock edge k loads the formed word. Bit i (i = 0 first, the LSB) drives `ser_out` from edge k+1+i onward. If no new strobe arrives, zeros follow the tenth bit.
- R3: With `narrow_mode` = 1, the formed word is {word_in[7:0], 2'b00}, and word_in[9:8] has no effect. With `narrow_mode` = 0, the formed word is word_in[9:0].
- R4: Each clock, the scrambled bit is s = d XOR q[3] XOR q[8], where d is the shifted-out bit and q is the 9-bit state. s then enters q at bit 0. The state advances every clock, bypass or not, so a receiver-side descrambler recovers d.
- R5: With `bypass` = 0, the NRZI level toggles when s = 1 and holds when s = 0, and `ser_out` is that new level, registered.
- R6: With `bypass` = 1, `ser_out` is the raw shifted-out bit d, with the same one-register latency.
- R7: `sync_flag` rises one edge after the third word of the sequence 0x3FF, 0x000, 0x000 (formed words) is loaded. It stays high until one edge after the next word is loaded.
- R8: With `sync_off` = 1, `sync_flag` is 0 from the next edge onward. The word history keeps updating, so the flag returns one edge after `sync_off` falls if the last three words still match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_en | input | 1 | Word strobe, one cycle per ten bit clocks |
| word_in | input | 10 | Parallel word |
| narrow_mode | input | 1 | 1: 8-bit source on word_in[7:0] |
| bypass | input | 1 | 1: raw serializer bits to output |
| sync_off | input | 1 | 1: sync flag forced low |
| ser_out | output | 1 | Serial data |
| sync_flag | output | 1 | Timing reference preamble seen |

## Verification
A strobe at edge k produces bit i on `ser_out` after edge k+1+i, and the sync flag reflects the word history one edge after the word that completes it. The bench drives inputs on falling edges and samples on the following falling edge. A bench-side model advances on each rising edge, so every comparison falls exactly one register after the edge that caused it. Scrambled output is also decoded by a bench descrambler. That comparison is paused for twelve bits after bypass, which lets the self-synchronizing state flush before checking resumes.

// File: rtl/vser_pkg.sv
package vser_pkg;
  localparam int unsigned WORD_W_DEF   = 10;
  localparam int unsigned NARROW_W_DEF = 8;
  localparam int unsigned SCR_LEN_DEF  = 9;
  localparam int unsigned SCR_TAP_DEF  = 4;
  localparam int unsigned HDR_LEN_DEF  = 3;

  typedef enum logic {
    FMT_FULL   = 1'b0,
    FMT_NARROW = 1'b1
  } word_fmt_e;
endpackage

// File: rtl/vser_loader.sv
module vser_loader
  import vser_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              narrow_mode,
  output logic [WORD_W-1:0] word_fmt,
  output logic              raw_bit
);
  localparam int unsigned PAD   = WORD_W - NARROW_W;
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  word_fmt_e         fmt;

  assign fmt = narrow_mode ? FMT_NARROW : FMT_FULL;

  generate
    if (PAD > 0) begin : g_pad
      assign word_fmt = (fmt == FMT_NARROW) ?
                        {word_in[NARROW_W-1:0], {PAD{1'b0}}} : word_in;
    end else begin : g_nopad
      assign word_fmt = word_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (word_en) begin
      sh_q  <= word_fmt;
      cnt_q <= '0;
    end else begin
      sh_q <= sh_q >> 1;
      if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign raw_bit = sh_q[0];

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W));
  // R2
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(WORD_W)) |-> (sh_q == '0));
  // R2
  load_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    word_en |=> (raw_bit == $past(word_fmt[0])));
endmodule

// File: rtl/vser_scrambler.sv
module vser_scrambler
  import vser_pkg::*;
#(
  parameter int unsigned SCR_LEN = SCR_LEN_DEF,
  parameter int unsigned SCR_TAP = SCR_TAP_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bypass,
  input  logic raw_bit,
  output logic ser_out
);
  logic [SCR_LEN-1:0] st_q;
  logic               lvl_q;
  logic               out_q;
  logic               scr_bit;
  logic               lvl_nxt;

  generate
    if (SCR_TAP >= SCR_LEN || SCR_TAP == 0) begin : g_bad_tap
      initial $error("scrambler tap out of range");
    end
  endgenerate

  assign scr_bit = raw_bit ^ st_q[SCR_TAP-1] ^ st_q[SCR_LEN-1];
  assign lvl_nxt = lvl_q ^ scr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      lvl_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      st_q  <= {st_q[SCR_LEN-2:0], scr_bit};
      lvl_q <= lvl_nxt;
      out_q <= bypass ? raw_bit : lvl_nxt;
    end
  end

  assign ser_out = out_q;

  // R6
  bypass_raw_chk: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (ser_out == $past(raw_bit)));
  // R5
  nrzi_level_chk: assert property (@(posedge clk) disable iff (rst)
    !bypass |=> (ser_out == lvl_q));
  // R4
  state_shift_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (st_q[SCR_LEN-1:1] == $past(st_q[SCR_LEN-2:0])));
endmodule

// File: rtl/vser_syncdet.sv
module vser_syncdet
  import vser_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned HDR_LEN = HDR_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_ld,
  input  logic [WORD_W-1:0] word_fmt,
  input  logic              sync_off,
  output logic              sync_flag
);
  logic [WORD_W-1:0] hist_q [HDR_LEN];
  logic [HDR_LEN-1:0] hit;
  logic               flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HDR_LEN; i++) hist_q[i] <= '0;
    end else if (word_ld) begin
      hist_q[0] <= word_fmt;
      for (int i = 1; i < HDR_LEN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g < HDR_LEN; g++) begin : g_hit
      if (g == HDR_LEN - 1) begin : g_ones
        assign hit[g] = (hist_q[g] == {WORD_W{1'b1}});
      end else begin : g_zero
        assign hit[g] = (hist_q[g] == '0);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= !sync_off && (&hit);
  end

  assign sync_flag = flag_q;

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    sync_off |=> !sync_flag);
  // R8
  flag_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    sync_flag |-> $past(!sync_off));
endmodule

// File: rtl/vid_serializer.sv
module vid_serializer
  import vser_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned SCR_LEN  = SCR_LEN_DEF,
  parameter int unsigned SCR_TAP  = SCR_TAP_DEF,
  parameter int unsigned HDR_LEN  = HDR_LEN_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              narrow_mode,
  input  logic              bypass,
  input  logic              sync_off,
  output logic              ser_out,
  output logic              sync_flag
);
  logic [WORD_W-1:0] word_fmt;
  logic              raw_bit;

  vser_loader #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_loader (
    .clk(clk), .rst(rst), .word_en(word_en), .word_in(word_in),
    .narrow_mode(narrow_mode), .word_fmt(word_fmt), .raw_bit(raw_bit)
  );

  vser_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
    .clk(clk), .rst(rst), .bypass(bypass), .raw_bit(raw_bit),
    .ser_out(ser_out)
  );

  vser_syncdet #(.WORD_W(WORD_W), .HDR_LEN(HDR_LEN)) u_sync (
    .clk(clk), .rst(rst), .word_ld(word_en), .word_fmt(word_fmt),
    .sync_off(sync_off), .sync_flag(sync_flag)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    rst |=> (!ser_out && !sync_flag));
endmodule

// File: tb/vid_serializer_tb.sv
`timescale 1ns/1ps
module vid_serializer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       word_en = 1'b0;
  logic [9:0] word_in = '0;
  logic       narrow_mode = 1'b0;
  logic       bypass = 1'b0;
  logic       sync_off = 1'b0;
  logic       ser_out, sync_flag;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vid_serializer u_dut (
    .clk(clk), .rst(rst), .word_en(word_en), .word_in(word_in),
    .narrow_mode(narrow_mode), .bypass(bypass), .sync_off(sync_off),
    .ser_out(ser_out), .sync_flag(sync_flag)
  );

  // reference model built from the requirements
  logic [9:0] m_word, h0, h1, h2;
  int         m_since;
  logic [8:0] m_s;
  logic       m_lvl, m_out, m_raw, m_byp, m_nar, m_sync, sb;

  function automatic logic [9:0] form(input logic [9:0] w, input logic nar);
    return nar ? {w[7:0], 2'b00} : w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_word = '0; m_since = 10; m_s = '0; m_lvl = 0; m_out = 0; m_raw = 0;
      m_byp = 0; m_nar = 0; m_sync = 0; h0 = '0; h1 = '0; h2 = '0;
    end else begin
      m_raw  = (m_since < 10) ? m_word[m_since] : 1'b0;
      sb     = m_raw ^ m_s[3] ^ m_s[8];
      m_s    = {m_s[7:0], sb};
      m_lvl  = m_lvl ^ sb;
      m_out  = bypass ? m_raw : m_lvl;
      m_byp  = bypass;
      m_nar  = narrow_mode;
      m_sync = !sync_off && h0 == 10'h000 && h1 == 10'h000 && h2 == 10'h3FF;
      if (word_en) begin
        m_word = form(word_in, narrow_mode);
        h2 = h1; h1 = h0; h0 = m_word;
        m_since = 0;
      end else if (m_since < 10) begin
        m_since++;
      end
    end
  end

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  // streaming comparison plus receiver-side descrambler
  logic [8:0] ds = '0;
  logic       prev_out = 1'b0;
  int         resync = 0;
  logic       rx, dd;

  always @(negedge clk) begin
    if (chk_on && !done) begin
      check(m_byp ? "R6 bypass stream" : (m_nar ? "R3/R5 stream" : "R2/R5 stream"),
            ser_out, m_out);
      check(m_sync ? "R7 flag" : "R8/R7 flag", sync_flag, m_sync);
      rx = ser_out ^ prev_out;
      dd = rx ^ ds[3] ^ ds[8];
      ds = {ds[7:0], rx};
      if (m_byp) resync = 12;
      else if (resync > 0) resync--;
      else check("R4 descramble", dd, m_raw);
      prev_out = ser_out;
    end
  end

  task automatic push_word(input logic [9:0] w);
    word_en = 1'b1;
    word_in = w;
    @(negedge clk);
    word_en = 1'b0;
    repeat (9) @(negedge clk);
  endtask

  task automatic push3(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c);
    push_word(a); push_word(b); push_word(c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ser_out", ser_out, 1'b0);
    check("R1 reset sync_flag", sync_flag, 1'b0);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1: zero words keep the line at 0 from the cleared state
    repeat (4) push_word(10'h000);
    check("R1 zero idle", ser_out, 1'b0);

    // R2 R4 R5: every 10-bit word, scrambled
    for (int v = 0; v < 1024; v++) push_word(v[9:0]);

    // R6: every word, raw
    bypass = 1'b1;
    for (int v = 0; v < 1024; v++) push_word(v[9:0] ^ 10'h155);

    // R2: zero fill after the tenth bit
    push_word(10'h3FF);
    repeat (4) @(negedge clk);
    check("R2 zero fill", ser_out, 1'b0);

    // R3: narrow mapping, upper pins toggled, raw then scrambled
    narrow_mode = 1'b1;
    for (int v = 0; v < 256; v++) push_word({v[1:0] ^ 2'b11, v[7:0]});
    bypass = 1'b0;
    for (int v = 0; v < 256; v++) push_word({2'b10, v[7:0]});

    // R3 R7: narrow 0xFF forms 0x3FC, no preamble
    push3(10'h0FF, 10'h000, 10'h000);
    check("R3 narrow no sync", sync_flag, 1'b0);
    narrow_mode = 1'b0;

    // R7: preamble found, near miss rejected
    push3(10'h3FF, 10'h000, 10'h000);
    check("R7 preamble", sync_flag, 1'b1);
    push3(10'h3FF, 10'h000, 10'h001);
    check("R7 near miss", sync_flag, 1'b0);
    push3(10'h3FF, 10'h000, 10'h000);
    check("R7 preamble again", sync_flag, 1'b1);

    // R8: disable forces low, history retained
    sync_off = 1'b1;
    @(negedge clk);
    check("R8 disabled", sync_flag, 1'b0);
    sync_off = 1'b0;
    @(negedge clk);
    check("R8 re-enabled", sync_flag, 1'b1);
    sync_off = 1'b1;
    push3(10'h3FF, 10'h000, 10'h000);
    check("R8 disabled preamble", sync_flag, 1'b0);
    sync_off = 1'b0;
    repeat (20) push_word(10'h2A5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule